// File: doc/BRIEF.md
# Serial Converter Port Controller

This block is the digital side of the four-wire serial port of a multichannel successive-approximation converter, written as a device-side model. A host selects the device with `ss_n`, clocks it with `sck` and sends an 8-bit control word on `sdi`. The block decodes the word into a channel selection, an input polarity, an input configuration and a power mode. It drives the acquisition switch and the hold-node switch at fixed serial-clock edges, and captures a 10-bit code from `code_in` at the instant of hold. That code stands in for the converter's decision loop. The block then announces the result with a one-period strobe and sends it MSB first on `sdo`.

All serial inputs are sampled on the system clock `clk`. An `sck` edge is seen as a change between two consecutive samples. The output pad drivers are enabled by `sdo_oe`, and both `sdo` and `strobe` float whenever the device is deselected. The power-mode bits decide whether the block falls asleep when a conversion ends. Clocking the port while selected wakes it again, and `pwr_off_n` forces it down.

Top module: `adc_sif`

## Requirements
- R1: While `ss_n` is high, `sck` rising edges are ignored: no word starts, `acq_en` stays 0 and `awake` is not set. `sdi` is sampled only on `sck` rising edges while `ss_n` is low.
- R2: `sdo_oe` is 0 (pads float) while `ss_n` is high and 1 while it is low. With no result pending, `sdo` is 0.
- R3: The first `sdi` 1 sampled while selected is the start bit. The seven bits that follow are, in arrival order: `sel[2]`, `sel[1]`, `sel[0]`, unipolar flag (1 = unipolar), single-ended flag (1 = single-ended), `pm[1]`, `pm[0]`. The decoded outputs change on the rise that carries the eighth bit. After reset they read `pos_ch`=0, `neg_ch`=8, `unipolar`=1, `pmode`=00.
- R4: `acq_en` goes high on the `sck` falling edge after the fifth word bit and low on the falling edge after the eighth, giving a three-period acquisition window.
- R5: `hold_neg` goes high on the falling edge after the eighth bit, and `code_in` is captured at that edge. It returns low on the falling edge after the rise that sends the result LSB. `acq_en` and `hold_neg` are never high together.
- R6: `pos_ch` equals `sel`. `neg_ch` is 8 (the common ground input) in single-ended mode, and `sel` with its bit 0 inverted (the other member of the pair 0/1, 2/3, 4/5 or 6/7) in pseudo-differential mode.
- R7: `strobe` is high for exactly one `sck` period, from the first rise after the eighth bit to the next rise, and `sdo` is 0 during it.
- R8: From the rise that ends the strobe, `sdo` carries the 10-bit result MSB first, one bit per rise. In unipolar mode the result is `code_in` unchanged. In bipolar mode its MSB is inverted, turning offset binary into two's complement. After the LSB, `sdo` is 0.
- R9: `pmode` shows the latched power bits: 11 normal, 10 reduced, 01 fast power-down, 00 full power-down. With `pm[1]`=0, `awake` falls on the falling edge after the LSB rise. Any `sck` rise while selected sets `awake`. Reset clears `awake`.
- R10: While `pwr_off_n` is low, `awake`, `acq_en` and `hold_neg` are 0 and any word in progress is dropped.
- R11: Raising `ss_n` in the middle of a word or result aborts it. The next selected period starts with a fresh start-bit search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_n | input | 1 | Device select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the device |
| pwr_off_n | input | 1 | Forced power-down, active low |
| code_in | input | 10 | Stand-in conversion code, offset binary |
| sdo | output | 1 | Serial data out of the device |
| strobe | output | 1 | One-period marker before the first result bit |
| sdo_oe | output | 1 | Pad driver enable for `sdo` and `strobe` |
| acq_en | output | 1 | Acquisition switch closed |
| hold_neg | output | 1 | Hold node switched to the negative input |
| pos_ch | output | 3 | Positive input channel |
| neg_ch | output | 4 | Negative input channel, 8 = common ground |
| unipolar | output | 1 | Latched polarity flag |
| pmode | output | 2 | Latched power mode |
| awake | output | 1 | Block powered up |

## Verification
The assertions assume that `ss_n`, `sck`, `sdi` and `pwr_off_n` are synchronous to `clk` and hold each level for at least two `clk` cycles. This means an `sck` edge is seen exactly once, and select changes never coincide with an `sck` edge. The bench keeps every `sck` half period at several `clk` cycles. It changes `sdi` and `ss_n` only while `sck` is low and well away from its edges, and it moves `pwr_off_n` only between frames or mid-word with `sck` at rest. Under those conditions it sweeps every channel code, both polarities, both input configurations and all four power modes, each with its own result code.

// File: rtl/adc_sif_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial converter port.
// Assumes eight input channels plus one common ground return.
package adc_sif_pkg;
    localparam int NUM_CH   = 8;
    localparam int SEL_W    = $clog2(NUM_CH);
    localparam int NEG_W    = $clog2(NUM_CH + 1);
    localparam int COM_CODE = NUM_CH;

    typedef enum logic [1:0] {
        PM_FULL_OFF = 2'b00,
        PM_FAST_OFF = 2'b01,
        PM_REDUCED  = 2'b10,
        PM_NORMAL   = 2'b11
    } pmode_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             uni;
        logic             sgl;
        pmode_t           pm;
    } cfg_t;

    localparam cfg_t CFG_RST = '{sel: '0, uni: 1'b1, sgl: 1'b1, pm: PM_FULL_OFF};
endpackage

// File: rtl/adc_sif_edge.sv
`timescale 1ns/1ps
// Detects serial clock edges by comparing the input with its last sample.
// Assumes sck is synchronous to clk and stable for at least two cycles per level.
module adc_sif_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    // Hold the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;
endmodule

// File: rtl/adc_sif_seq.sv
`timescale 1ns/1ps
// Frame sequencer: finds the start bit, collects the control word, times the
// acquisition and hold switches, the strobe and the power state.
// Assumes rise and fall are single-cycle pulses that never coincide.
module adc_sif_seq
    import adc_sif_pkg::*;
#(
    parameter int CTRL_BITS = 8,
    parameter int TRACK_BIT = 5,
    parameter int RES_BITS  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n,
    input  logic pwr_off_n,
    input  logic sdi,
    input  logic rise,
    input  logic fall,
    output cfg_t cfg,
    output logic acq_en,
    output logic hold_neg,
    output logic strb,
    output logic awake,
    output logic load,
    output logic shift_en
);
    localparam int FIELD_W  = CTRL_BITS - 1;
    localparam int STRB_CNT = CTRL_BITS;
    localparam int LSB_CNT  = CTRL_BITS + 1 + RES_BITS;
    localparam int CNT_W    = $clog2(LSB_CNT + 1);

    logic [CNT_W-1:0]   cnt;
    logic [FIELD_W-2:0] ctl_sh;
    logic               active;

    assign active   = !ss_n && pwr_off_n;
    assign load     = active && fall && (cnt == CNT_W'(CTRL_BITS));
    assign shift_en = rise && (cnt > CNT_W'(STRB_CNT)) && (cnt < CNT_W'(LSB_CNT));

    // Count serial rises through the word and result; latch the decoded word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            ctl_sh <= '0;
            cfg    <= CFG_RST;
            strb   <= 1'b0;
        end else if (!active) begin
            cnt  <= '0;
            strb <= 1'b0;
        end else if (rise) begin
            strb <= (cnt == CNT_W'(STRB_CNT));
            if (cnt == '0 || cnt == CNT_W'(LSB_CNT))
                cnt <= sdi ? CNT_W'(1) : '0;
            else
                cnt <= cnt + CNT_W'(1);
            if (cnt != '0 && cnt < CNT_W'(CTRL_BITS - 1))
                ctl_sh <= {ctl_sh[FIELD_W-3:0], sdi};
            if (cnt == CNT_W'(CTRL_BITS - 1))
                cfg <= cfg_t'({ctl_sh, sdi});
        end
    end

    // Open and close the acquisition and hold switches on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            acq_en   <= 1'b0;
            hold_neg <= 1'b0;
        end else if (fall) begin
            if (cnt == CNT_W'(TRACK_BIT)) acq_en <= 1'b1;
            if (cnt == CNT_W'(CTRL_BITS)) begin
                acq_en   <= 1'b0;
                hold_neg <= 1'b1;
            end
            if (cnt == CNT_W'(LSB_CNT)) hold_neg <= 1'b0;
        end
    end

    // Track the power state: serial clocking wakes, auto-off modes sleep at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_off_n)
            awake <= 1'b0;
        else if (!ss_n && rise)
            awake <= 1'b1;
        else if (!ss_n && fall && cnt == CNT_W'(LSB_CNT) && !cfg.pm[1])
            awake <= 1'b0;
    end
endmodule

// File: rtl/adc_sif_shift.sv
`timescale 1ns/1ps
// Result register: captures the code at hold, applies the polarity format and
// sends it MSB first. Assumes load and shift_en never occur in the same cycle.
module adc_sif_shift #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                load,
    input  logic                unipolar,
    input  logic [RES_BITS-1:0] code_in,
    input  logic                rise,
    input  logic                shift_en,
    output logic                sdo_q
);
    logic [RES_BITS-1:0] sh;

    // Load on hold, shift one bit per serial rise, otherwise send zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            sdo_q <= 1'b0;
        end else if (clr) begin
            sdo_q <= 1'b0;
        end else if (load) begin
            sh <= unipolar ? code_in : {~code_in[RES_BITS-1], code_in[RES_BITS-2:0]};
        end else if (rise) begin
            if (shift_en) begin
                sdo_q <= sh[RES_BITS-1];
                sh    <= {sh[RES_BITS-2:0], 1'b0};
            end else begin
                sdo_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_sif.sv
`timescale 1ns/1ps
// Serial converter port controller top. Decodes the channel pair and drives
// the pad enables. Assumes all serial inputs are synchronous to clk.
module adc_sif
    import adc_sif_pkg::*;
#(
    parameter int RES_BITS  = 10,
    parameter int CTRL_BITS = 8,
    parameter int TRACK_BIT = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ss_n,
    input  logic                sck,
    input  logic                sdi,
    input  logic                pwr_off_n,
    input  logic [RES_BITS-1:0] code_in,
    output logic                sdo,
    output logic                strobe,
    output logic                sdo_oe,
    output logic                acq_en,
    output logic                hold_neg,
    output logic [SEL_W-1:0]    pos_ch,
    output logic [NEG_W-1:0]    neg_ch,
    output logic                unipolar,
    output logic [1:0]          pmode,
    output logic                awake
);
    logic rise, fall, load, shift_en, strb, sdo_q;
    cfg_t cfg;

    adc_sif_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck(sck), .rise(rise), .fall(fall)
    );

    adc_sif_seq #(
        .CTRL_BITS(CTRL_BITS), .TRACK_BIT(TRACK_BIT), .RES_BITS(RES_BITS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .pwr_off_n(pwr_off_n), .sdi(sdi),
        .rise(rise), .fall(fall), .cfg(cfg), .acq_en(acq_en), .hold_neg(hold_neg),
        .strb(strb), .awake(awake), .load(load), .shift_en(shift_en)
    );

    adc_sif_shift #(.RES_BITS(RES_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(ss_n || !pwr_off_n), .load(load),
        .unipolar(cfg.uni), .code_in(code_in), .rise(rise), .shift_en(shift_en),
        .sdo_q(sdo_q)
    );

    // Channel decode: the negative side is the common return or the pair partner.
    assign pos_ch   = cfg.sel;
    assign neg_ch   = cfg.sgl ? NEG_W'(COM_CODE)
                              : NEG_W'({cfg.sel[SEL_W-1:1], ~cfg.sel[0]});
    assign unipolar = cfg.uni;
    assign pmode    = cfg.pm;

    assign sdo_oe = !ss_n;
    assign sdo    = sdo_q;
    assign strobe = strb;
endmodule

// File: rtl/adc_sif_chk.sv
`timescale 1ns/1ps
// Protocol checker for adc_sif, attached with bind. Assumes serial inputs
// hold each level for at least two clk cycles.
module adc_sif_chk (
    input logic clk,
    input logic rst_n,
    input logic ss_n,
    input logic sck,
    input logic pwr_off_n,
    input logic sdo,
    input logic strobe,
    input logic acq_en,
    input logic hold_neg,
    input logic awake
);
    a_r1_acq_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_en) |-> $past(!ss_n));

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(acq_en && hold_neg));

    a_r5_hold_after_acq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_neg) |-> $past(acq_en));

    a_r7_strobe_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !sdo);

    a_r9_clock_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && pwr_off_n && $rose(sck)) |=> awake);

    a_r10_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_off_n |=> (!awake && !acq_en && !hold_neg));

    a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |=> (!acq_en && !hold_neg));
endmodule

bind adc_sif adc_sif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .pwr_off_n(pwr_off_n),
    .sdo(sdo), .strobe(strobe), .acq_en(acq_en), .hold_neg(hold_neg), .awake(awake)
);

// File: tb/sim_adc_sif.sv
`timescale 1ns/1ps
// Bench for adc_sif: sweeps every control word configuration with computed results.
module sim_adc_sif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ss_n = 1'b1, sck = 1'b0, sdi = 1'b0, pwr_off_n = 1'b1;
    logic [9:0] code_in = '0;
    logic       sdo, strobe, sdo_oe, acq_en, hold_neg, unipolar, awake;
    logic [2:0] pos_ch;
    logic [3:0] neg_ch;
    logic [1:0] pmode;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    adc_sif u0 (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .sdi(sdi),
        .pwr_off_n(pwr_off_n), .code_in(code_in), .sdo(sdo), .strobe(strobe),
        .sdo_oe(sdo_oe), .acq_en(acq_en), .hold_neg(hold_neg), .pos_ch(pos_ch),
        .neg_ch(neg_ch), .unipolar(unipolar), .pmode(pmode), .awake(awake)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rise_edge(input logic b);
        @(negedge clk); sdi = b;
        repeat (2) @(negedge clk); sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic fall_edge();
        sck = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // One full frame: start bit, seven word bits, strobe, ten result bits, trailing zero.
    task automatic frame(input logic [2:0] sel, input logic uni, input logic sgl,
                         input logic [1:0] pd, input logic [9:0] code);
        logic [6:0] w;
        logic [9:0] exp_r;
        w     = {sel, uni, sgl, pd};
        exp_r = uni ? code : {~code[9], code[8:0]};
        code_in = code;
        rise_edge(1'b1); fall_edge();
        for (int i = 6; i >= 0; i--) begin
            rise_edge(w[i]);
            if (i == 0) begin
                check("R3 pos_ch", 16'(pos_ch), 16'(sel));
                check("R6 neg_ch", 16'(neg_ch), sgl ? 16'd8 : 16'({sel[2:1], ~sel[0]}));
                check("R3 unipolar", 16'(unipolar), 16'(uni));
                check("R9 pmode", 16'(pmode), 16'(pd));
            end
            fall_edge();
            if (i == 3) check("R4 acq opens", 16'(acq_en), 16'd1);
            if (i == 0) begin
                check("R4 acq closes", 16'(acq_en), 16'd0);
                check("R5 hold set", 16'(hold_neg), 16'd1);
            end
        end
        rise_edge(1'b0);
        check("R7 strobe high", 16'(strobe), 16'd1);
        check("R7 sdo low in strobe", 16'(sdo), 16'd0);
        fall_edge();
        for (int b = 9; b >= 0; b--) begin
            rise_edge(1'b0);
            check("R7 strobe one period", 16'(strobe), 16'd0);
            check("R8 result bit", 16'(sdo), 16'(exp_r[b]));
            fall_edge();
        end
        check("R5 hold released", 16'(hold_neg), 16'd0);
        check("R9 awake after end", 16'(awake), 16'(pd[1]));
        rise_edge(1'b0);
        check("R8 trailing zero", 16'(sdo), 16'd0);
        check("R9 wake by clock", 16'(awake), 16'd1);
        fall_edge();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // Reset state.
        check("R2 oe off deselected", 16'(sdo_oe), 16'd0);
        check("R3 reset pos_ch", 16'(pos_ch), 16'd0);
        check("R3 reset neg_ch", 16'(neg_ch), 16'd8);
        check("R3 reset unipolar", 16'(unipolar), 16'd1);
        check("R9 reset pmode", 16'(pmode), 16'd0);
        check("R9 reset asleep", 16'(awake), 16'd0);

        // R1: clocking while deselected is ignored.
        for (int k = 0; k < 8; k++) begin rise_edge(1'b1); fall_edge(); end
        ss_n = 1'b0; repeat (3) @(negedge clk);
        check("R1 no acq", 16'(acq_en), 16'd0);
        check("R1 not woken", 16'(awake), 16'd0);
        check("R2 oe on selected", 16'(sdo_oe), 16'd1);
        check("R2 sdo idle zero", 16'(sdo), 16'd0);
        rise_edge(1'b0); fall_edge();
        check("R9 clock wakes", 16'(awake), 16'd1);
        check("R1 zero is not start", 16'(acq_en), 16'd0);

        // Sweep of every channel, polarity, configuration; power bits follow sel.
        for (int s = 0; s < 8; s++)
            for (int u = 0; u < 2; u++)
                for (int g = 0; g < 2; g++) begin
                    int idx;
                    logic [9:0] cd;
                    idx = s * 4 + u * 2 + g;
                    cd  = (idx == 0) ? 10'h000 : (idx == 31) ? 10'h3FF
                                     : 10'((idx * 293 + 17) % 1024);
                    frame(3'(s), u[0], g[0], 2'(s), cd);
                end

        // R11: abort mid-word, then a fresh frame decodes correctly.
        rise_edge(1'b1); fall_edge();
        rise_edge(1'b0); fall_edge(); rise_edge(1'b1); fall_edge();
        rise_edge(1'b0); fall_edge(); rise_edge(1'b1); fall_edge();
        check("R11 acq before abort", 16'(acq_en), 16'd1);
        ss_n = 1'b1; repeat (3) @(negedge clk);
        check("R11 acq aborted", 16'(acq_en), 16'd0);
        check("R2 oe off on abort", 16'(sdo_oe), 16'd0);
        ss_n = 1'b0; repeat (3) @(negedge clk);
        frame(3'd5, 1'b0, 1'b0, 2'b11, 10'h155);

        // R10: forced power-down mid-word.
        rise_edge(1'b1); fall_edge();
        for (int k = 0; k < 4; k++) begin rise_edge(1'b0); fall_edge(); end
        check("R10 acq before off", 16'(acq_en), 16'd1);
        pwr_off_n = 1'b0; repeat (3) @(negedge clk);
        check("R10 asleep", 16'(awake), 16'd0);
        check("R10 acq dropped", 16'(acq_en), 16'd0);
        rise_edge(1'b1); fall_edge();
        check("R10 held asleep", 16'(awake), 16'd0);
        pwr_off_n = 1'b1; repeat (3) @(negedge clk);
        frame(3'd2, 1'b1, 1'b0, 2'b10, 10'h2AA);

        // R9: auto-off mode stays asleep while deselected.
        frame(3'd7, 1'b1, 1'b1, 2'b01, 10'h0F0);
        rise_edge(1'b0); fall_edge();
        rise_edge(1'b1); fall_edge();
        for (int k = 0; k < 7; k++) begin rise_edge(1'b0); fall_edge(); end
        for (int k = 0; k < 11; k++) begin rise_edge(1'b0); fall_edge(); end
        ss_n = 1'b1; repeat (3) @(negedge clk);
        check("R9 fast off sleeps", 16'(awake), 16'd0);
        rise_edge(1'b0); fall_edge();
        check("R1 deselected clock no wake", 16'(awake), 16'd0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule